// File: doc/BRIEF.md
# Interrupt Aggregation and GPIO Register Bank

This block is the system control register bank of a companion I/O device. A host reaches it through single-byte reads and writes on an 8-bit offset; registers wider than one byte sit least-significant byte first at consecutive offsets, and each byte is written on its own. Eight level-sensitive interrupt lines from sub-devices feed a status byte. Whenever a line changes level, its status bit takes the new level. The host can overwrite the status byte and set a mask byte. One combined interrupt output goes to the host while any status bit is set with its mask bit set. The lines are numbered 0 flash controller, 1 card slot, 2 USB host, 3 serial port and 4 display.

The bank also holds sixteen general-purpose output bits with a data byte pair and an enable byte pair. The driven level of each bit is data AND enable. In the cycle after any data or enable write, a one-cycle change pulse vector flags every bit whose driven level changed, and a level vector gives the current driven levels. Clock, PLL, buffer, mode and configuration registers are plain read/write storage. A fixed revision value is readable. Reads from any other offset return zero and writes to them are dropped.

Top module: `sys_ctrl_bank`

## Requirements
- R1: When sub-device line k changes level between clock edges, status bit k (read at offset 0x50, bit k) holds the new level after the next rising edge.
- R2: `irq_o` is high exactly when the status byte AND the mask byte (offset 0x52, 1 enables) is nonzero, evaluated on register contents.
- R3: A host write to offset 0x50 replaces the status bits whose line did not change in that cycle; bits whose line changed in that same cycle take the line level instead; `irq_o` follows the new status in the next cycle.
- R4: Offset 0x08 reads 0x03 and offset 0x09 reads 0x00; writes to either have no effect on what they read.
- R5: GPIO data bytes sit at 0x78 (bits 7:0) and 0x79 (bits 15:8), enable bytes at 0x7C (bits 7:0) and 0x7D (bits 15:8); each reads back as written. Offsets 0x7A and 0x7E are accepted but carry no bits and read 0x00.
- R6: `gpio_lvl_o` always equals data AND enable.
- R7: In the cycle after a data or enable write, `gpio_chg_o` has a 1 exactly on the bits whose driven level changed, and it returns to zero in the following cycle when no further write occurs.
- R8: Multi-byte storage registers (clock control 0x98-0x99, PLL2 0x9A-0x9B, PLL1 0x9C-0x9F, mode control 0xE4-0xE5, enable word 0x60-0x61, others) update only the byte lane at the written offset.
- R9: A read from an unmapped offset returns 0x00, and a write to one changes no register and no output.
- R10: After reset every register reads 0x00, `irq_o` is low, and both GPIO vectors are zero with no change pulse.
- R11: The mask byte at 0x52 reads back the last value written to it.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte offset for read and write |
| wr_en_i | input | 1 | Write strobe for the byte at `addr_i` |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| sub_irq_i | input | N_SRC (8) | Level interrupt lines from sub-devices |
| irq_o | output | 1 | Combined masked interrupt |
| gpio_lvl_o | output | GPIO_W (16) | Driven GPIO levels, data AND enable |
| gpio_chg_o | output | GPIO_W (16) | One-cycle pulse per bit whose driven level changed |

## Verification
A stale line-tracking register would leave a status bit at its old level one cycle after a line transition, which shows at once in a read of 0x50 and usually in `irq_o`. A wrong previous-level copy in the output path shows in the cycle right after a write as missing or extra bits in `gpio_chg_o`, or as a pulse that lasts a second cycle. A lane decode error in the storage registers shows as a corrupted neighbour byte on the next read of that register. Random line patterns, masks and GPIO writes are run against bench models, and directed cases cover the same-cycle write and line change, the empty third lane and the fixed revision.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam logic [7:0] OFF_REV   = 8'h08;
  localparam logic [7:0] OFF_STAT  = 8'h50;
  localparam logic [7:0] OFF_MASK  = 8'h52;
  localparam logic [7:0] OFF_GDATA = 8'h78;
  localparam logic [7:0] OFF_GOE   = 8'h7C;
  localparam logic [7:0] REV_VAL   = 8'h03;
  localparam int         GPIO_LANES_MAX = 3;

  localparam int NUM_PLAIN = 20;
  // routing, enable word, buffer word, clock word, PLL2 word, PLL1 long,
  // device control bytes, function enable, mode word, config, debug
  localparam logic [7:0] PLAIN_OFFS [NUM_PLAIN] = '{
    8'h54, 8'h60, 8'h61, 8'h94, 8'h95, 8'h98, 8'h99, 8'h9A, 8'h9B, 8'h9C,
    8'h9D, 8'h9E, 8'h9F, 8'hA0, 8'hA1, 8'hE0, 8'hE4, 8'hE5, 8'hFC, 8'hFF
  };
endpackage

// File: rtl/irq_agg.sv
module irq_agg #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_stat_i,
  input  logic             wr_mask_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       stat_o,
  output logic [7:0]       mask_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] line_q, stat_q, mask_q, stat_n;

  // a line transition wins over a host write to the same bit
  always_comb begin
    stat_n = stat_q;
    for (int k = 0; k < N_SRC; k++) begin
      if (src_i[k] != line_q[k])  stat_n[k] = src_i[k];
      else if (wr_stat_i)         stat_n[k] = wdata_i[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      line_q <= src_i;
      stat_q <= stat_n;
      if (wr_mask_i) mask_q <= wdata_i[N_SRC-1:0];
    end
  end

  assign stat_o = 8'(stat_q);
  assign mask_o = 8'(mask_q);
  assign irq_o  = |(stat_q & mask_q);

  assert_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_i ^ line_q) != '0) |=>
      ((stat_q & $past(src_i ^ line_q)) == ($past(src_i) & $past(src_i ^ line_q))));

  assert_mask_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);

  assert_host_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i && (src_i == line_q)) |=> (stat_q == $past(wdata_i[N_SRC-1:0])));
endmodule

// File: rtl/gpio_out.sv
module gpio_out
  import sysctl_pkg::*;
#(
  parameter int GPIO_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic              hit_o,
  output logic [7:0]        rdata_o,
  output logic [GPIO_W-1:0] lvl_o,
  output logic [GPIO_W-1:0] chg_o
);
  logic [7:0] d_off, e_off;
  logic       d_hit, e_hit, wr_any;
  logic [GPIO_W-1:0] data_q, oe_q, data_n, oe_n, eff, prev_q;

  assign d_off  = addr_i - OFF_GDATA;
  assign e_off  = addr_i - OFF_GOE;
  assign d_hit  = d_off < 8'(GPIO_LANES_MAX);
  assign e_hit  = e_off < 8'(GPIO_LANES_MAX);
  assign hit_o  = d_hit | e_hit;
  assign wr_any = wr_en_i & hit_o;

  always_comb begin
    data_n  = data_q;
    oe_n    = oe_q;
    rdata_o = '0;
    for (int b = 0; b < GPIO_W; b++) begin
      if (wr_en_i && d_hit && d_off == 8'(b / 8)) data_n[b] = wdata_i[3'(b % 8)];
      if (wr_en_i && e_hit && e_off == 8'(b / 8)) oe_n[b]   = wdata_i[3'(b % 8)];
      if (d_hit && d_off == 8'(b / 8)) rdata_o[3'(b % 8)] = data_q[b];
      if (e_hit && e_off == 8'(b / 8)) rdata_o[3'(b % 8)] = oe_q[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      oe_q   <= '0;
      prev_q <= '0;
    end else begin
      data_q <= data_n;
      oe_q   <= oe_n;
      prev_q <= eff;
    end
  end

  assign eff   = data_q & oe_q;
  assign lvl_o = eff;
  assign chg_o = eff ^ prev_q;

  assert_lvl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_o & ~oe_q) == '0);

  assert_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_o != '0) |-> $past(wr_any));
endmodule

// File: rtl/plain_store.sv
module plain_store #(
  parameter int         N = 4,
  parameter logic [7:0] OFFS [N] = '{default: 8'h00}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  output logic       hit_o,
  output logic [7:0] rdata_o
);
  logic [7:0] q [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q[i] <= '0;
      else if (wr_en_i && addr_i == OFFS[i])  q[i] <= wdata_i;
    end

    assert_lane_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && addr_i == OFFS[i]) |=> $stable(q[i]));
  end

  always_comb begin
    hit_o   = 1'b0;
    rdata_o = '0;
    for (int i = 0; i < N; i++) begin
      if (addr_i == OFFS[i]) begin
        hit_o   = 1'b1;
        rdata_o = q[i];
      end
    end
  end
endmodule

// File: rtl/sys_ctrl_bank.sv
module sys_ctrl_bank
  import sysctl_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int GPIO_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [N_SRC-1:0]  sub_irq_i,
  output logic              irq_o,
  output logic [GPIO_W-1:0] gpio_lvl_o,
  output logic [GPIO_W-1:0] gpio_chg_o
);
  logic [7:0] stat, mask, g_rd, p_rd;
  logic       g_hit, p_hit;

  irq_agg #(.N_SRC(N_SRC)) i_irq (
    .clk_i, .rst_ni,
    .src_i     (sub_irq_i),
    .wr_stat_i (wr_en_i && addr_i == OFF_STAT),
    .wr_mask_i (wr_en_i && addr_i == OFF_MASK),
    .wdata_i,
    .stat_o    (stat),
    .mask_o    (mask),
    .irq_o
  );

  gpio_out #(.GPIO_W(GPIO_W)) i_gpio (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i,
    .hit_o   (g_hit),
    .rdata_o (g_rd),
    .lvl_o   (gpio_lvl_o),
    .chg_o   (gpio_chg_o)
  );

  plain_store #(.N(NUM_PLAIN), .OFFS(PLAIN_OFFS)) i_store (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i,
    .hit_o   (p_hit),
    .rdata_o (p_rd)
  );

  always_comb begin
    if (g_hit)                  rdata_o = g_rd;
    else if (p_hit)             rdata_o = p_rd;
    else if (addr_i == OFF_REV) rdata_o = REV_VAL;
    else if (addr_i == OFF_STAT) rdata_o = stat;
    else if (addr_i == OFF_MASK) rdata_o = mask;
    else                        rdata_o = 8'h00;
  end

  assert_rev_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_REV) |-> (rdata_o == 8'h03));

  assert_mask_rb_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_MASK) |=> (mask == $past(wdata_i)));
endmodule

// File: tb/test_sys_ctrl_bank.sv
module test_sys_ctrl_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic        wr = 1'b0;
  logic [7:0]  sub = '0;
  logic        irq;
  logic [15:0] lvl, chg;

  int n_chk = 0, n_fail = 0;

  logic [7:0]  line_m = '0, stat_m = '0, mask_m = '0;
  logic [15:0] dat_m = '0, oe_m = '0;

  always #5 clk = ~clk;

  sys_ctrl_bank i_sys_ctrl_bank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .sub_irq_i(sub), .irq_o(irq),
    .gpio_lvl_o(lvl), .gpio_chg_o(chg)
  );

  function automatic logic [15:0] eff_f(input logic [15:0] d, input logic [15:0] e);
    return d & e;
  endfunction

  function automatic logic irq_f(input logic [7:0] s, input logic [7:0] m);
    return (s & m) != 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, return at the next negedge
  task automatic cyc(input logic [7:0] s, input logic we, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sub = s; wr = we; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  // bench model of the status byte
  task automatic model_irq(input logic [7:0] s, input logic we, input logic [7:0] a, input logic [7:0] d);
    for (int k = 0; k < 8; k++) begin
      if (s[k] != line_m[k])          stat_m[k] = s[k];
      else if (we && a == 8'h50)      stat_m[k] = d[k];
    end
    line_m = s;
    if (we && a == 8'h52) mask_m = d;
  endtask

  task automatic gpio_wr(input logic [7:0] a, input logic [7:0] d);
    logic [15:0] old_e, new_e;
    old_e = eff_f(dat_m, oe_m);
    case (a)
      8'h78: dat_m[7:0]  = d;
      8'h79: dat_m[15:8] = d;
      8'h7C: oe_m[7:0]   = d;
      8'h7D: oe_m[15:8]  = d;
      default: ;
    endcase
    new_e = eff_f(dat_m, oe_m);
    cyc(sub, 1'b1, a, d);
    chk("R7 change pulse", chg, old_e ^ new_e);
    chk("R6 level", lvl, new_e);
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] s, a, d;
    logic       we;
    int unused_seed;
    unused_seed = $urandom(32'd4242);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(8'h50, v); chk("R10 status", v, 8'h00);
    rd(8'h52, v); chk("R10 mask", v, 8'h00);
    rd(8'h78, v); chk("R10 gpio data", v, 8'h00);
    rd(8'h9C, v); chk("R10 pll1", v, 8'h00);
    chk("R10 irq", irq, 1'b0);
    chk("R10 chg", chg, 16'h0);
    chk("R10 lvl", lvl, 16'h0);

    // R4 revision
    rd(8'h08, v); chk("R4 rev lo", v, 8'h03);
    rd(8'h09, v); chk("R4 rev hi", v, 8'h00);
    cyc(sub, 1'b1, 8'h08, 8'h55);
    cyc(sub, 1'b1, 8'h09, 8'hAA);
    rd(8'h08, v); chk("R4 rev after write", v, 8'h03);
    rd(8'h09, v); chk("R4 rev hi after write", v, 8'h00);

    // R11 mask, R1 / R2 directed
    cyc(sub, 1'b1, 8'h52, 8'h11); model_irq(sub, 1'b1, 8'h52, 8'h11);
    rd(8'h52, v); chk("R11 mask readback", v, 8'h11);
    cyc(8'h10, 1'b0, 8'h00, 8'h00); model_irq(8'h10, 1'b0, 8'h00, 8'h00);
    rd(8'h50, v); chk("R1 display line sets status", v, 8'h10);
    chk("R2 irq on masked source", irq, 1'b1);
    cyc(8'h12, 1'b0, 8'h00, 8'h00); model_irq(8'h12, 1'b0, 8'h00, 8'h00);
    rd(8'h50, v); chk("R1 card line", v, 8'h12);
    cyc(8'h02, 1'b0, 8'h00, 8'h00); model_irq(8'h02, 1'b0, 8'h00, 8'h00);
    rd(8'h50, v); chk("R1 line falls", v, 8'h02);
    chk("R2 unmasked source alone", irq, 1'b0);

    // R3 host write, then write colliding with a line change
    cyc(8'h02, 1'b1, 8'h50, 8'h01); model_irq(8'h02, 1'b1, 8'h50, 8'h01);
    rd(8'h50, v); chk("R3 host write status", v, 8'h01);
    chk("R3 irq after write", irq, 1'b1);
    cyc(8'h06, 1'b1, 8'h50, 8'h00); model_irq(8'h06, 1'b1, 8'h50, 8'h00);
    rd(8'h50, v); chk("R3 line change wins", v, 8'h04);
    chk("R3 irq cleared", irq, 1'b0);

    // random interrupt traffic
    for (int i = 0; i < 150; i++) begin
      s = 8'($urandom);
      we = ($urandom % 3) == 0;
      a = (($urandom % 2) == 0) ? 8'h50 : 8'h52;
      d = 8'($urandom);
      cyc(s, we, a, d);
      model_irq(s, we, a, d);
      chk("R2 random irq", irq, irq_f(stat_m, mask_m));
      rd(8'h50, v); chk("R1 random status", v, stat_m);
    end

    // GPIO directed: R5 R6 R7
    gpio_wr(8'h7C, 8'hFF);
    gpio_wr(8'h78, 8'hA5);
    @(negedge clk);
    chk("R7 pulse ends", chg, 16'h0);
    gpio_wr(8'h7A, 8'hFF);
    rd(8'h7A, v); chk("R5 empty data lane", v, 8'h00);
    gpio_wr(8'h7E, 8'hFF);
    rd(8'h7E, v); chk("R5 empty enable lane", v, 8'h00);
    gpio_wr(8'h79, 8'h3C);
    rd(8'h79, v); chk("R5 data hi readback", v, 8'h3C);
    gpio_wr(8'h7D, 8'h0F);
    rd(8'h7D, v); chk("R5 enable hi readback", v, 8'h0F);
    chk("R6 level directed", lvl, 16'h0CA5);

    for (int i = 0; i < 200; i++) begin
      case ($urandom % 4)
        0: a = 8'h78;
        1: a = 8'h79;
        2: a = 8'h7C;
        default: a = 8'h7D;
      endcase
      gpio_wr(a, 8'($urandom));
      rd(a, v);
      case (a)
        8'h78: chk("R5 random readback", v, dat_m[7:0]);
        8'h79: chk("R5 random readback", v, dat_m[15:8]);
        8'h7C: chk("R5 random readback", v, oe_m[7:0]);
        default: chk("R5 random readback", v, oe_m[15:8]);
      endcase
    end

    // R8 byte lanes
    cyc(sub, 1'b1, 8'h9C, 8'h11);
    cyc(sub, 1'b1, 8'h9D, 8'h22);
    cyc(sub, 1'b1, 8'h9E, 8'h33);
    cyc(sub, 1'b1, 8'h9F, 8'h44);
    cyc(sub, 1'b1, 8'h9E, 8'h77);
    rd(8'h9C, v); chk("R8 pll1 b0", v, 8'h11);
    rd(8'h9D, v); chk("R8 pll1 b1", v, 8'h22);
    rd(8'h9E, v); chk("R8 pll1 b2", v, 8'h77);
    rd(8'h9F, v); chk("R8 pll1 b3", v, 8'h44);
    cyc(sub, 1'b1, 8'hE4, 8'hC3);
    cyc(sub, 1'b1, 8'hE5, 8'h5A);
    cyc(sub, 1'b1, 8'hE4, 8'h0F);
    rd(8'hE4, v); chk("R8 mode lo", v, 8'h0F);
    rd(8'hE5, v); chk("R8 mode hi", v, 8'h5A);

    // R9 unmapped offsets
    cyc(sub, 1'b1, 8'h40, 8'hFF);
    chk("R9 no gpio change", chg, 16'h0);
    chk("R9 level kept", lvl, eff_f(dat_m, oe_m));
    cyc(sub, 1'b1, 8'h51, 8'hFF);
    chk("R9 irq kept", irq, irq_f(stat_m, mask_m));
    rd(8'h40, v); chk("R9 unmapped read", v, 8'h00);
    rd(8'h51, v); chk("R9 unmapped read 51", v, 8'h00);
    rd(8'h50, v); chk("R9 status kept", v, stat_m);
    rd(8'h9C, v); chk("R9 storage kept", v, 8'h11);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule